// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a general-purpose up-counter with one compare value. Software drives it through a small word-addressed register port that has one-cycle read latency, and it raises one level interrupt. The counter advances on a selected tick. Two tick-enable inputs, one fast and one slow, arrive from the clock tree, and a clock-source field picks between them. A 12-bit prescaler then divides the chosen tick stream by (prescaler + 1).

The block has two counting modes. In restart mode the counter runs from zero up to the compare value and then starts again from zero, so it produces a periodic compare event. In free-run mode the counter covers its whole range. It flags the compare match as it passes it and flags a rollover when it wraps from all-ones to zero. Both events are latched as status flags. Software clears them by writing 1s, and it can mask each of them into the interrupt line. A self-clearing soft-reset bit returns the datapath to its initial state but keeps most of the configuration.

Top module: `gp_timer`

## Requirements
- R1: After the synchronous reset, every control bit, the prescaler, both status flags and the interrupt enables are zero, the compare value is all-ones, the counter is zero and `irq` is low.
- R2: Word offsets are 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 compare and 9 counter. Read data appears on `bus_rdata` one cycle after the address. Control bits 15:10 read as 0. The prescaler keeps 12 bits and the interrupt enable keeps 6 bits. Status reads show only bit 0 (compare flag) and bit 5 (rollover flag). Any other offset reads 0, and writes to it change nothing.
- R3: Control bits 8:6 choose the tick: codes 001 and 010 select `tick_fast`, code 100 selects `tick_slow`, and every other code selects no tick. The counter advances once per (prescaler+1) selected ticks, and only while control bit 0 (enable) is set. Writing the prescaler restarts the division.
- R4: In restart mode (control bit 9 = 0), an advance while the counter equals the compare value sets the compare flag and loads zero. Otherwise an advance adds one.
- R5: In free-run mode (control bit 9 = 1), an advance while the counter equals the compare value sets the compare flag and still adds one. An advance from all-ones wraps to zero and sets the rollover flag.
- R6: Writing status with a 1 in bit 0 or bit 5 clears that flag. A 0 leaves it unchanged.
- R7: A flag that is set by an event in the same cycle as a write-1-to-clear of that flag stays set.
- R8: `irq` is high one cycle after the enable bit is set and (compare flag AND enable bit 0) or (rollover flag AND enable bit 5) holds. Enable bits 4:1 have no effect.
- R9: A control write with bit 15 set ignores the rest of the written data. It clears control bits 0, 2, 3 and 4 and keeps the other control bits. It clears the status flags, prescaler, interrupt enables and counter, and sets the compare value to all-ones. Bit 15 never reads back as 1.
- R10: If a control write turns the enable bit from 0 to 1 with bit 1 (enable mode) set, the counter is cleared. Otherwise the counter keeps its value and resumes from it. While the timer is disabled the counter holds.
- R11: A compare write in restart mode clears the counter. A compare write in free-run mode leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Fast tick enable, one cycle per tick |
| tick_slow | input | 1 | Slow tick enable, one cycle per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench builds the block with an 8-bit counter and the default 12-bit prescaler. With the short counter, the free-run wrap from all-ones to zero and the all-ones compare value are reached in a few hundred ticks, so the rollover flag, the wrap itself and the compare-versus-rollover distinction are all checked within a short run. The full-width prescaler is kept so that the field's masking and the divide-by-three path run against the real register layout.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
  localparam int DATA_W = 32;
  localparam int IEN_W  = 6;

  // register word offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_PRE  = 1;
  localparam int OFF_STAT = 2;
  localparam int OFF_IEN  = 3;
  localparam int OFF_CMP  = 4;
  localparam int OFF_CNT  = 9;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_ENMOD = 1;
  localparam int CB_SRC_LO = 6;
  localparam int CB_FREE  = 9;
  localparam int CB_SWR   = 15;

  // status / enable bit positions
  localparam int ST_CMP = 0;
  localparam int ST_ROV = 5;

  // bits a soft reset keeps, bits that always read zero
  localparam logic [DATA_W-1:0] CTRL_SWR_KEEP = 32'hFFFF_FFE2;
  localparam logic [DATA_W-1:0] CTRL_STORED   = 32'hFFFF_03FF;

  typedef enum logic [1:0] {ROUTE_NONE, ROUTE_FAST, ROUTE_SLOW} tick_route_e;

  function automatic tick_route_e route_of(input logic [2:0] src);
    case (src)
      3'b001, 3'b010: route_of = ROUTE_FAST;
      3'b100:         route_of = ROUTE_SLOW;
      default:        route_of = ROUTE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gp_timer_tick.sv
module gp_timer_tick
  import gp_timer_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [2:0]       src,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [PRE_W-1:0] pre,
  output logic             adv
);
  logic [PRE_W-1:0] div_q;
  logic             tick_sel;

  always_comb begin
    case (route_of(src))
      ROUTE_FAST: tick_sel = tick_fast;
      ROUTE_SLOW: tick_sel = tick_slow;
      default:    tick_sel = 1'b0;
    endcase
  end

  assign adv = run & tick_sel & (div_q == pre);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run && tick_sel) begin
      div_q <= (div_q == pre) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/gp_timer_count.sv
module gp_timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             free_run,
  input  logic             clear,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_cmp,
  output logic             hit_wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_cmp;
  logic             at_top;

  assign at_cmp   = (cnt_q == cmp);
  assign at_top   = &cnt_q;
  assign hit_cmp  = adv & at_cmp;
  assign hit_wrap = adv & free_run & at_top;
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (!free_run && at_cmp) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(OFF_PRE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFF_CMP);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);

  logic [DATA_W-1:0] ctrl_q;
  logic [PRE_W-1:0]  pre_q;
  logic [IEN_W-1:0]  ien_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              flag_cmp_q;
  logic              flag_rov_q;
  logic              irq_q;
  logic [DATA_W-1:0] rdata_q;

  logic [CNT_W-1:0]  cnt_q;
  logic              adv;
  logic              hit_cmp;
  logic              hit_wrap;

  logic wr_ctrl, wr_pre, wr_stat, wr_ien, wr_cmp;
  logic soft_rst, en_rise, cnt_clear;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_pre  = bus_wr && (bus_addr == A_PRE);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_ien  = bus_wr && (bus_addr == A_IEN);
  assign wr_cmp  = bus_wr && (bus_addr == A_CMP);

  assign soft_rst  = wr_ctrl && bus_wdata[CB_SWR];
  assign en_rise   = wr_ctrl && !soft_rst && !ctrl_q[CB_EN] && bus_wdata[CB_EN];
  assign cnt_clear = soft_rst
                   || (en_rise && bus_wdata[CB_ENMOD])
                   || (wr_cmp && !ctrl_q[CB_FREE]);

  gp_timer_tick #(.PRE_W(PRE_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q[CB_EN]),
    .clr       (soft_rst || wr_pre),
    .src       (ctrl_q[CB_SRC_LO+2:CB_SRC_LO]),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .pre       (pre_q),
    .adv       (adv)
  );

  gp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .free_run (ctrl_q[CB_FREE]),
    .clear    (cnt_clear),
    .cmp      (cmp_q),
    .cnt      (cnt_q),
    .hit_cmp  (hit_cmp),
    .hit_wrap (hit_wrap)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '1;
    end else if (soft_rst) begin
      ctrl_q <= ctrl_q & CTRL_SWR_KEEP;
      pre_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_STORED;
      if (wr_pre)  pre_q  <= bus_wdata[PRE_W-1:0];
      if (wr_ien)  ien_q  <= bus_wdata[IEN_W-1:0];
      if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
    end
  end

  // event flags: a new event outranks a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      flag_cmp_q <= 1'b0;
      flag_rov_q <= 1'b0;
    end else begin
      flag_cmp_q <= hit_cmp  | (flag_cmp_q & ~(wr_stat & bus_wdata[ST_CMP]));
      flag_rov_q <= hit_wrap | (flag_rov_q & ~(wr_stat & bus_wdata[ST_ROV]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ctrl_q[CB_EN] & ((flag_cmp_q & ien_q[ST_CMP]) |
                                       (flag_rov_q & ien_q[ST_ROV]));
  end

  // registered read port
  logic [DATA_W-1:0] stat_word;
  always_comb begin
    stat_word         = '0;
    stat_word[ST_CMP] = flag_cmp_q;
    stat_word[ST_ROV] = flag_rov_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:  rdata_q <= ctrl_q;
        A_PRE:   rdata_q <= DATA_W'(pre_q);
        A_STAT:  rdata_q <= stat_word;
        A_IEN:   rdata_q <= DATA_W'(ien_q);
        A_CMP:   rdata_q <= DATA_W'(cmp_q);
        A_CNT:   rdata_q <= DATA_W'(cnt_q);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk
  import gp_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic              ctrl_en,
  input logic              ctrl_free
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(bus_addr) == ADDR_W'(OFF_CTRL)) |-> (bus_rdata[15:10] == 6'd0)); // R2

  AST_IEN_WIDTH: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(bus_addr) == ADDR_W'(OFF_IEN)) |-> (bus_rdata[DATA_W-1:IEN_W] == '0)); // R2

  AST_STAT_BITS_ONLY: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(bus_addr) == ADDR_W'(OFF_STAT)) |-> ((bus_rdata & ~32'h21) == '0)); // R6

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[CB_SWR])
      |-> (cnt == '0 && cmp == '1 && !ctrl_en)); // R9

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst || !past_ok)
    irq |-> $past(ctrl_en)); // R8

  AST_CMP_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(bus_wr && bus_addr == ADDR_W'(OFF_CMP) && !ctrl_free) |-> (cnt == '0)); // R11

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$stable(cnt) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1)); // R4
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt       (cnt_q),
  .cmp       (cmp_q),
  .ctrl_en   (ctrl_q[0]),
  .ctrl_free (ctrl_q[9])
);

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  localparam logic [1:0] OW = 2'd0;  // write
  localparam logic [1:0] OR = 2'd1;  // read and compare
  localparam logic [1:0] OF = 2'd2;  // fast ticks
  localparam logic [1:0] OS = 2'd3;  // slow ticks

  localparam logic [3:0] AC = 4'd0;
  localparam logic [3:0] AP = 4'd1;
  localparam logic [3:0] AS = 4'd2;
  localparam logic [3:0] AI = 4'd3;
  localparam logic [3:0] AO = 4'd4;
  localparam logic [3:0] AN = 4'd9;

  localparam int NV = 79;
  // {op, requirement, addr, data/count, expected}
  localparam logic [73:0] VEC [0:NV-1] = '{
    {OR, 4'd1, AC, 32'd0, 32'h0},           // R1
    {OR, 4'd1, AP, 32'd0, 32'h0},           // R1
    {OR, 4'd1, AS, 32'd0, 32'h0},           // R1
    {OR, 4'd1, AI, 32'd0, 32'h0},           // R1
    {OR, 4'd1, AO, 32'd0, 32'hFF},          // R1
    {OR, 4'd1, AN, 32'd0, 32'h0},           // R1
    {OW, 4'd2, AC, 32'h7C40, 32'h0},        // R2 bits 14:10 dropped
    {OR, 4'd2, AC, 32'd0, 32'h40},
    {OW, 4'd2, AP, 32'hFFFFF002, 32'h0},    // R2 prescaler 12 bits
    {OR, 4'd2, AP, 32'd0, 32'h002},
    {OW, 4'd4, AO, 32'h05, 32'h0},
    {OW, 4'd10, AC, 32'h43, 32'h0},
    {OF, 4'd3, AC, 32'd7, 32'h0},           // R3 divide by 3
    {OR, 4'd3, AN, 32'd0, 32'h2},
    {OF, 4'd3, AC, 32'd2, 32'h0},
    {OR, 4'd3, AN, 32'd0, 32'h3},
    {OW, 4'd3, AP, 32'h0, 32'h0},
    {OF, 4'd4, AC, 32'd2, 32'h0},           // R4
    {OR, 4'd4, AN, 32'd0, 32'h5},
    {OR, 4'd4, AS, 32'd0, 32'h0},
    {OF, 4'd4, AC, 32'd1, 32'h0},
    {OR, 4'd4, AN, 32'd0, 32'h0},
    {OR, 4'd4, AS, 32'd0, 32'h1},
    {OS, 4'd3, AC, 32'd3, 32'h0},           // R3 slow ignored
    {OR, 4'd3, AN, 32'd0, 32'h0},
    {OW, 4'd6, AS, 32'h20, 32'h0},          // R6
    {OR, 4'd6, AS, 32'd0, 32'h1},
    {OW, 4'd6, AS, 32'h0, 32'h0},
    {OR, 4'd6, AS, 32'd0, 32'h1},
    {OW, 4'd6, AS, 32'h1, 32'h0},
    {OR, 4'd6, AS, 32'd0, 32'h0},
    {OF, 4'd11, AC, 32'd3, 32'h0},          // R11
    {OR, 4'd11, AN, 32'd0, 32'h3},
    {OW, 4'd11, AO, 32'h10, 32'h0},
    {OR, 4'd11, AN, 32'd0, 32'h0},
    {OW, 4'd10, AC, 32'h243, 32'h0},        // R10 no edge, held
    {OW, 4'd11, AO, 32'h02, 32'h0},
    {OR, 4'd11, AN, 32'd0, 32'h0},
    {OF, 4'd5, AC, 32'd3, 32'h0},           // R5
    {OR, 4'd5, AS, 32'd0, 32'h1},
    {OW, 4'd5, AS, 32'h1, 32'h0},
    {OF, 4'd5, AC, 32'd252, 32'h0},
    {OR, 4'd5, AN, 32'd0, 32'hFF},
    {OR, 4'd5, AS, 32'd0, 32'h0},
    {OF, 4'd5, AC, 32'd1, 32'h0},
    {OR, 4'd5, AN, 32'd0, 32'h0},
    {OR, 4'd5, AS, 32'd0, 32'h20},
    {OF, 4'd5, AC, 32'd5, 32'h0},
    {OR, 4'd5, AS, 32'd0, 32'h21},
    {OW, 4'd11, AO, 32'h80, 32'h0},
    {OR, 4'd11, AN, 32'd0, 32'h5},
    {OW, 4'd10, AC, 32'h242, 32'h0},        // R10
    {OF, 4'd10, AC, 32'd4, 32'h0},
    {OR, 4'd10, AN, 32'd0, 32'h5},
    {OW, 4'd10, AC, 32'h241, 32'h0},
    {OF, 4'd10, AC, 32'd1, 32'h0},
    {OR, 4'd10, AN, 32'd0, 32'h6},
    {OW, 4'd10, AC, 32'h240, 32'h0},
    {OW, 4'd10, AC, 32'h243, 32'h0},
    {OR, 4'd10, AN, 32'd0, 32'h0},
    {OF, 4'd9, AC, 32'd2, 32'h0},           // R9
    {OW, 4'd9, AP, 32'h3, 32'h0},
    {OW, 4'd9, AI, 32'h21, 32'h0},
    {OW, 4'd9, AC, 32'h25F, 32'h0},
    {OR, 4'd9, AN, 32'd0, 32'h2},
    {OW, 4'd9, AC, 32'h8000, 32'h0},
    {OR, 4'd9, AC, 32'd0, 32'h242},
    {OR, 4'd9, AP, 32'd0, 32'h0},
    {OR, 4'd9, AI, 32'd0, 32'h0},
    {OR, 4'd9, AO, 32'd0, 32'hFF},
    {OR, 4'd9, AS, 32'd0, 32'h0},
    {OR, 4'd9, AN, 32'd0, 32'h0},
    {OW, 4'd2, AI, 32'hFF, 32'h0},          // R2 enable 6 bits
    {OR, 4'd2, AI, 32'd0, 32'h3F},
    {OW, 4'd2, AI, 32'h0, 32'h0},
    {OW, 4'd2, 4'd5, 32'h1234, 32'h0},      // R2 unmapped
    {OR, 4'd2, 4'd5, 32'd0, 32'h0},
    {OR, 4'd2, 4'd7, 32'd0, 32'h0},
    {OR, 4'd2, AC, 32'd0, 32'h242}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_timer #(.CNT_W(8), .PRE_W(12), .ADDR_W(4)) u_gp_timer (
    .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ticks(input bit slow, input int n);
    for (int i = 0; i < n; i++) begin
      tick_fast = !slow; tick_slow = slow;
      @(negedge clk);
    end
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic irq_after(input string req, input logic exp);
    @(negedge clk);
    check(req, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", {31'd0, irq}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][73:72])
        OW: wr(VEC[v][67:64], VEC[v][63:32]);
        OR: begin
          rd(VEC[v][67:64], d);
          check($sformatf("R%0d row %0d", VEC[v][71:68], v), d, VEC[v][31:0]);
        end
        OF: ticks(1'b0, int'(VEC[v][63:32]));
        default: ticks(1'b1, int'(VEC[v][63:32]));
      endcase
    end

    // R3: other clock codes
    wr(AC, 32'h100); wr(AC, 32'h103);
    ticks(1'b1, 4); rd(AN, d); check("R3 slow code", d, 32'h4);
    ticks(1'b0, 2); rd(AN, d); check("R3 fast ignored on slow code", d, 32'h4);
    wr(AC, 32'h0C0); wr(AC, 32'h0C3);
    ticks(1'b0, 3); ticks(1'b1, 3); rd(AN, d); check("R3 code 011 no tick", d, 32'h0);
    wr(AC, 32'h080); wr(AC, 32'h083);
    ticks(1'b0, 2); rd(AN, d); check("R3 code 010 fast", d, 32'h2);

    // R8: interrupt path
    wr(AC, 32'h040); wr(AC, 32'h043);
    wr(AO, 32'h0); wr(AP, 32'h0); wr(AS, 32'h21); wr(AI, 32'h01);
    irq_after("R8 idle", 1'b0);
    ticks(1'b0, 1);
    check("R8 latency", {31'd0, irq}, 32'd0);
    irq_after("R8 raised", 1'b1);
    wr(AI, 32'h1E); irq_after("R8 unused enables", 1'b0);
    wr(AI, 32'h20); irq_after("R8 rollover enable only", 1'b0);
    wr(AI, 32'h01); irq_after("R8 compare enable", 1'b1);
    wr(AC, 32'h042); irq_after("R8 disabled", 1'b0);
    wr(AC, 32'h041); irq_after("R8 re-enabled", 1'b1);

    // R6 and R7: clear versus same-cycle event
    wr(AS, 32'h1); rd(AS, d); check("R6 clear", d, 32'h0);
    bus_addr = AS; bus_wdata = 32'h1; bus_wr = 1'b1; tick_fast = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_fast = 1'b0;
    rd(AS, d); check("R7 set wins", d, 32'h1);
    wr(AS, 32'h1); rd(AS, d); check("R6 clear again", d, 32'h0);

    // R1: hard reset again
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    rd(AC, d); check("R1 ctrl", d, 32'h0);
    rd(AO, d); check("R1 compare", d, 32'hFF);
    rd(AN, d); check("R1 counter", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule